// File: doc/BRIEF.md
# Binary-Weight Convolution Window

This block forms one sum of products between a square window of signed pixels and a kernel whose weights are restricted to +1 or -1. The weights are binary, so the block has no multiplier. For each tap it passes the pixel through unchanged or takes its two's-complement negation, as the tap's single weight bit selects. A balanced adder tree then adds up the 49 signed terms.

The datapath is fixed at 7x7. A two-bit size select shrinks the active window to a centred 5x5 or 3x3. Taps outside the active window are forced to contribute nothing, and their operands are held at zero so that they do not toggle. The result is registered once, so it appears on the cycle after the inputs are presented, together with a matching valid flag. The unit sits between a window generator and a per-channel accumulator. It is used once per output channel per input channel.

Top module: `binw_conv_window`

## Requirements
- R1: The sum of the active taps appears on sum_o, with vld_o high, on the first rising edge after the inputs are presented with vld_i high.
- R2: Weight bit i equal to 1 makes tap i contribute the negated pixel. Weight bit i equal to 0 makes tap i contribute the pixel unchanged.
- R3: sum_o is 18 bits signed and never overflows. All 49 pixels at -2048 give -100352 with all weights 0 and +100352 with all weights 1.
- R4: Size select 2'b00 chooses 3x3. Only rows 2..4 and columns 2..4 are active, where tap i = row*7 + col, pixel i occupies pix_i[12*i +: 12], and weight i is wgt_i[i].
- R5: Size select 2'b01 chooses 5x5, which makes rows 1..5 and columns 1..5 active.
- R6: Size selects 2'b10 and 2'b11 both choose the full 7x7 window.
- R7: An inactive tap contributes zero whatever its pixel or weight bit.
- R8: vld_o is vld_i delayed by one cycle. While vld_i is low, sum_o keeps its previous value.
- R9: A synchronous active-high reset clears vld_o and sum_o to zero on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vld_i | input | 1 | Inputs valid this cycle |
| ksel_i | input | 2 | Window size select (00 = 3x3, 01 = 5x5, 1x = 7x7) |
| pix_i | input | 588 | 49 signed 12-bit pixels, tap i at bits 12*i+11..12*i |
| wgt_i | input | 49 | Binary weights, bit i for tap i (1 = negate) |
| vld_o | output | 1 | Result valid |
| sum_o | output | 18 | Signed window sum |

## Verification
Uniform windows of one pixel value with all-zero and all-one weights separate the pass-through case from the negate case. At -2048 and 2047, the same windows reach both extremes of the sum and expose any truncation or sign-extension fault. An alternating weight pattern shows that each tap obeys its own bit. A ring pattern carries 1 in the centre 3x3 and a large value outside it. Run across all four size selects, it tells apart the 3x3, 5x5 and 7x7 masks. With ones placed only on the outer weights, it shows that masked taps ignore both pixel and weight. Directed cases cover reset, holding the sum while the valid input is low, and a reset in mid-run.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int PIX_W = 12;
  localparam int KDIM  = 7;
  localparam int TAPS  = KDIM * KDIM;
  localparam int SUM_W = PIX_W + $clog2(TAPS);

  typedef enum logic [1:0] {
    KS_3X3  = 2'b00,
    KS_5X5  = 2'b01,
    KS_7X7  = 2'b10,
    KS_7X7B = 2'b11
  } ksize_e;
endpackage

// File: rtl/bwc_tap_mask.sv
module bwc_tap_mask #(
  parameter int KDIM = bwc_pkg::KDIM
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             ksel_i,
  output logic [KDIM*KDIM-1:0]   act_o
);
  localparam int CTR = KDIM / 2;
  localparam int RW  = $clog2(KDIM) + 1;
  localparam int N   = KDIM * KDIM;

  logic [RW-1:0] rad;

  always_comb begin
    case (ksel_i)
      bwc_pkg::KS_3X3: rad = RW'(1);
      bwc_pkg::KS_5X5: rad = RW'(2);
      default:         rad = RW'(CTR);
    endcase
  end

  for (genvar r = 0; r < KDIM; r++) begin : g_row
    for (genvar c = 0; c < KDIM; c++) begin : g_col
      localparam int DR   = (r > CTR) ? r - CTR : CTR - r;
      localparam int DC   = (c > CTR) ? c - CTR : CTR - c;
      localparam int DIST = (DR > DC) ? DR : DC;
      assign act_o[r*KDIM+c] = (RW'(DIST) <= rad);
    end
  end

  AST_MASK_SIZE: assert property (@(posedge clk) disable iff (rst)
    $countones(act_o) == ((ksel_i == bwc_pkg::KS_3X3) ? 9 :
                          (ksel_i == bwc_pkg::KS_5X5) ? 25 : N)); // R4
endmodule

// File: rtl/bwc_sign_tap.sv
module bwc_sign_tap #(
  parameter int PIX_W = bwc_pkg::PIX_W,
  parameter int SUM_W = bwc_pkg::SUM_W
) (
  input  logic signed [PIX_W-1:0] pix_i,
  input  logic                    w_i,
  input  logic                    act_i,
  output logic signed [SUM_W-1:0] term_o
);
  logic signed [PIX_W-1:0] pix_g;
  logic                    w_g;
  logic signed [SUM_W-1:0] ext;

  // operand gating: idle taps see constant zero
  assign pix_g  = act_i ? pix_i : '0;
  assign w_g    = act_i & w_i;
  assign ext    = {{(SUM_W-PIX_W){pix_g[PIX_W-1]}}, pix_g};
  assign term_o = w_g ? -ext : ext;
endmodule

// File: rtl/bwc_adder_tree.sv
module bwc_adder_tree #(
  parameter int N = bwc_pkg::TAPS,
  parameter int W = bwc_pkg::SUM_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en_i,
  input  logic [N*W-1:0]       terms_i,
  output logic signed [W-1:0]  sum_o
);
  localparam int LEAVES = 1 << $clog2(N);
  localparam int NODES  = 2 * LEAVES - 1;

  logic signed [W-1:0] node [NODES];

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < N) begin : g_used
      assign node[LEAVES-1+i] = terms_i[i*W +: W];
    end else begin : g_pad
      assign node[LEAVES-1+i] = '0;
    end
  end

  for (genvar n = 0; n < LEAVES - 1; n++) begin : g_add
    assign node[n] = node[2*n+1] + node[2*n+2];
  end

  always_ff @(posedge clk) begin
    if (rst)       sum_o <= '0;
    else if (en_i) sum_o <= node[0];
  end

  AST_HOLD_SUM: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> $stable(sum_o)); // R8
endmodule

// File: rtl/binw_conv_window.sv
module binw_conv_window #(
  parameter int PIX_W = bwc_pkg::PIX_W,
  parameter int KDIM  = bwc_pkg::KDIM,
  localparam int TAPS = KDIM * KDIM,
  localparam int SUM_W = PIX_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld_i,
  input  logic [1:0]              ksel_i,
  input  logic [TAPS*PIX_W-1:0]   pix_i,
  input  logic [TAPS-1:0]         wgt_i,
  output logic                    vld_o,
  output logic signed [SUM_W-1:0] sum_o
);
  localparam int LIM = TAPS * (1 << (PIX_W - 1));

  logic [TAPS-1:0]       act;
  logic [TAPS*SUM_W-1:0] terms;

  bwc_tap_mask #(.KDIM(KDIM)) u_mask (
    .clk    (clk),
    .rst    (rst),
    .ksel_i (ksel_i),
    .act_o  (act)
  );

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    logic signed [SUM_W-1:0] t;
    bwc_sign_tap #(.PIX_W(PIX_W), .SUM_W(SUM_W)) u_tap (
      .pix_i  (pix_i[i*PIX_W +: PIX_W]),
      .w_i    (wgt_i[i]),
      .act_i  (act[i]),
      .term_o (t)
    );
    assign terms[i*SUM_W +: SUM_W] = t;

    AST_GATE_ZERO: assert property (@(posedge clk) disable iff (rst)
      !act[i] |-> t == '0); // R7
    AST_SIGN_SEL: assert property (@(posedge clk) disable iff (rst)
      act[i] |-> (wgt_i[i] ? (t == -SUM_W'($signed(pix_i[i*PIX_W +: PIX_W])))
                           : (t ==  SUM_W'($signed(pix_i[i*PIX_W +: PIX_W]))))); // R2
  end

  bwc_adder_tree #(.N(TAPS), .W(SUM_W)) u_tree (
    .clk     (clk),
    .rst     (rst),
    .en_i    (vld_i),
    .terms_i (terms),
    .sum_o   (sum_o)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_o <= 1'b0;
    else     vld_o <= vld_i;
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
    vld_i |=> vld_o); // R8
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst)
    !vld_i |=> !vld_o); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    vld_o |-> ($signed(sum_o) <= LIM && $signed(sum_o) >= -LIM)); // R3
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!vld_o && sum_o == '0)); // R9
endmodule

// File: tb/tb_binw_conv_window.sv
module tb_binw_conv_window;
  localparam int PW = 12;
  localparam int KD = 7;
  localparam int NT = KD * KD;
  localparam int SW = 18;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               vld_i = 1'b0;
  logic [1:0]         ksel_i = 2'b00;
  logic [NT*PW-1:0]   pix_i = '0;
  logic [NT-1:0]      wgt_i = '0;
  logic               vld_o;
  logic signed [SW-1:0] sum_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  binw_conv_window dut (
    .clk(clk), .rst(rst), .vld_i(vld_i), .ksel_i(ksel_i),
    .pix_i(pix_i), .wgt_i(wgt_i), .vld_o(vld_o), .sum_o(sum_o)
  );

  // pm: 0 = all pixels v, 1 = centre 3x3 at 1 and ring at v
  // wm: 0 all zero, 1 all one, 2 bit i = i%2, 3 ones outside centre 3x3
  typedef struct packed {
    logic             pm;
    logic signed [11:0] v;
    logic [1:0]       wm;
    logic [1:0]       ks;
    int               expv;
    int               req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t TBL [NV] = '{
    '{1'b0,  12'sd5,     2'd0, 2'd0,      45, 1},  // R1
    '{1'b0,  12'sd5,     2'd1, 2'd2,    -245, 2},  // R2
    '{1'b0, -12'sd2048,  2'd0, 2'd2, -100352, 3},  // R3
    '{1'b0, -12'sd2048,  2'd1, 2'd2,  100352, 3},  // R3
    '{1'b0,  12'sd2047,  2'd0, 2'd1,   51175, 5},  // R5
    '{1'b0,  12'sd100,   2'd2, 2'd2,     100, 2},  // R2
    '{1'b1,  12'sd1000,  2'd0, 2'd0,       9, 4},  // R4
    '{1'b1,  12'sd1000,  2'd0, 2'd1,   16009, 5},  // R5
    '{1'b1,  12'sd1000,  2'd0, 2'd2,   40009, 6},  // R6
    '{1'b1,  12'sd1000,  2'd0, 2'd3,   40009, 6},  // R6
    '{1'b1,  12'sd1000,  2'd3, 2'd0,       9, 7},  // R7
    '{1'b1,  12'sd1000,  2'd3, 2'd2,  -39991, 7},  // R7
    '{1'b0, -12'sd7,     2'd1, 2'd0,      63, 2}   // R2
  };

  task automatic chk(input int req, input int act, input int expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL R%0d actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic load(input vec_t e);
    for (int i = 0; i < NT; i++) begin
      int r = i / KD;
      int c = i % KD;
      bit inner = (r >= 2 && r <= 4 && c >= 2 && c <= 4);
      pix_i[i*PW +: PW] = (e.pm && inner) ? 12'sd1 : e.v;
      case (e.wm)
        2'd0: wgt_i[i] = 1'b0;
        2'd1: wgt_i[i] = 1'b1;
        2'd2: wgt_i[i] = i[0];
        default: wgt_i[i] = !inner;
      endcase
    end
    ksel_i = e.ks;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: state after reset
    chk(9, int'(vld_o), 0);
    chk(9, int'($signed(sum_o)), 0);

    // table walk: R1..R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      load(TBL[k]);
      vld_i = 1'b1;
      @(posedge clk);
      #1;
      chk(1, int'(vld_o), 1);
      chk(TBL[k].req, int'($signed(sum_o)), TBL[k].expv);
      @(negedge clk);
      vld_i = 1'b0;
    end

    // R8: hold while vld_i low, new inputs ignored
    @(negedge clk);
    load(TBL[0]);
    vld_i = 1'b1;
    @(negedge clk);
    vld_i = 1'b0;
    load(TBL[3]);
    @(posedge clk);
    #1;
    chk(8, int'(vld_o), 0);
    chk(8, int'($signed(sum_o)), 45);
    @(negedge clk);
    chk(8, int'($signed(sum_o)), 45);

    // R8: back-to-back valid
    load(TBL[1]);
    vld_i = 1'b1;
    @(negedge clk);
    load(TBL[8]);
    @(posedge clk);
    #1;
    chk(8, int'(vld_o), 1);
    chk(6, int'($signed(sum_o)), 40009);
    @(negedge clk);
    vld_i = 1'b0;

    // R9: mid-run reset
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk(9, int'(vld_o), 0);
    chk(9, int'($signed(sum_o)), 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule